// File: doc/BRIEF.md
# Plotter Sense Status and Interrupt Latch

This block sits in a plotter controller and answers the host's sense-device requests. A request counts as a sense only while the sense strobe and the plotter's area decode are both high, which lasts one memory cycle of roughly eight timing steps. For that cycle the block drives three active-high status bits. Bit 0 means an interrupt is pending. Bit 14 means a command is still running. Bit 15 means the plotter's supply has been detected. When the cycle ends, the block releases all three bits. External open-collector inverters turn these bits into the active-low host lines.

The block also keeps a sticky level-3 interrupt request. The command sequencer's completion pulse sets it. Only a sense that carries the reset-bit-15 qualifier clears it, and the clear takes effect when that sense cycle ends. This keeps bit 0 steady for the whole window in which the host samples it. The plotter-power flag comes from an analog detector with no relation to the clock, so it passes through a synchronizer of parameterized depth before it is used.

Top module: `plotter_status_irq`

## Requirements
- R1: While `rst_ni` is low, `irq_o`, `stat0_o`, `stat14_o` and `stat15_o` are all 0.
- R2: If `sense_i` and `area_i` are not both high, the status outputs stay 0, whatever the state of busy, power or the interrupt.
- R3: During a sense, `stat15_o` equals the power-present flag once that flag has been stable for `SYNC_STAGES`+1 clocks.
- R4: During a sense, `stat14_o` equals `busy_i` as sampled one clock earlier.
- R5: A one-clock `done_i` pulse sets `irq_o` on the next clock edge, and `irq_o` stays set through later clocks and through senses that lack the clear qualifier.
- R6: During a sense, `stat0_o` equals the value `irq_o` had one clock earlier.
- R7: A sense with `clr15_i` high in any of its cycles returns the full current status, including bit 0, for its whole duration. `irq_o` falls on the first clock edge after the sense ends, and later senses show bit 0 as 0.
- R8: Status outputs fall to 0 on the first clock edge after `sense_i` or `area_i` drops.
- R9: If `done_i` is high on the edge where a clear would take effect, `irq_o` stays 1.
- R10: A `clr15_i` pulse outside a sense cycle has no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sense_i | input | 1 | Sense-device strobe from the host |
| area_i | input | 1 | Area decode selecting this plotter |
| clr15_i | input | 1 | Interrupt-reset qualifier (command word bit 15) |
| done_i | input | 1 | One-clock completion pulse from the command sequencer |
| busy_i | input | 1 | Command-in-progress flag from the sequencer |
| pwr_i | input | 1 | Plotter supply detected, asynchronous |
| irq_o | output | 1 | Level-3 interrupt request, active high |
| stat0_o | output | 1 | Status bit 0: interrupt pending |
| stat14_o | output | 1 | Status bit 14: busy |
| stat15_o | output | 1 | Status bit 15: plotter ready |

## Verification
The sense path is driven with the strobe alone, the area decode alone, and both together, which separates real sense cycles from partial decodes. Full senses run with power off and on, busy low and high, and the interrupt pending or idle, so each status bit is shown to follow only its own source. Senses with and without the clear qualifier, a qualifier outside any sense, and a completion pulse landing on the clear edge together tell the sticky latch apart from a level-following or edge-early clear.

// File: rtl/plt_stat_pkg.sv
package plt_stat_pkg;
    typedef struct packed {
        logic pend;   // bit 0
        logic busy;   // bit 14
        logic ready;  // bit 15
    } stat_t;

    localparam stat_t STAT_IDLE = '{pend: 1'b0, busy: 1'b0, ready: 1'b0};
endpackage

// File: rtl/plt_sync.sv
module plt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/plt_irq_ctl.sv
module plt_irq_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sense_act_i,
    input  logic clr15_i,
    input  logic done_i,
    output logic irq_o
);
    typedef struct packed {
        logic in_sense;
        logic armed;
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       sense_end;

    always_comb begin
        st_d          = st_q;
        sense_end     = st_q.in_sense && !sense_act_i;
        st_d.in_sense = sense_act_i;
        // qualifier is remembered for the whole cycle, dropped once it ends
        st_d.armed    = sense_act_i ? (st_q.armed || clr15_i) : 1'b0;
        if (done_i)
            st_d.irq = 1'b1;
        else if (sense_end && st_q.armed)
            st_d.irq = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/plt_stat_enc.sv
module plt_stat_enc
    import plt_stat_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sense_act_i,
    input  logic  irq_i,
    input  logic  busy_i,
    input  logic  ready_i,
    output stat_t stat_o
);
    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = STAT_IDLE;
        if (sense_act_i) begin
            stat_d.pend  = irq_i;
            stat_d.busy  = busy_i;
            stat_d.ready = ready_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= STAT_IDLE;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/plotter_status_irq.sv
module plotter_status_irq
    import plt_stat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sense_i,
    input  logic area_i,
    input  logic clr15_i,
    input  logic done_i,
    input  logic busy_i,
    input  logic pwr_i,
    output logic irq_o,
    output logic stat0_o,
    output logic stat14_o,
    output logic stat15_o
);
    logic  sense_act;
    logic  ready;
    logic  irq;
    stat_t stat;

    assign sense_act = sense_i && area_i;

    plt_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pwr_i),
        .q_o   (ready)
    );

    plt_irq_ctl u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sense_act_i(sense_act),
        .clr15_i    (clr15_i),
        .done_i     (done_i),
        .irq_o      (irq)
    );

    plt_stat_enc u_enc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sense_act_i(sense_act),
        .irq_i      (irq),
        .busy_i     (busy_i),
        .ready_i    (ready),
        .stat_o     (stat)
    );

    assign irq_o    = irq;
    assign stat0_o  = stat.pend;
    assign stat14_o = stat.busy;
    assign stat15_o = stat.ready;
endmodule

// File: rtl/plotter_status_irq_chk.sv
module plotter_status_irq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sense_i,
    input logic area_i,
    input logic clr15_i,
    input logic done_i,
    input logic busy_i,
    input logic irq_o,
    input logic stat0_o,
    input logic stat14_o,
    input logic stat15_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            a_r1_reset_quiet: assert (!irq_o && !stat0_o && !stat14_o && !stat15_o);
    end

    a_r2_no_sense_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(sense_i && area_i) |-> !(stat0_o || stat14_o || stat15_o));

    a_r4_busy_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat14_o |-> $past(busy_i));

    a_r5_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> irq_o);

    a_r6_bit0_mirrors: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat0_o |-> $past(irq_o));

    a_r7_clear_after_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> !$past(sense_i && area_i));

    a_r9_done_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> !$past(done_i));
endmodule

bind plotter_status_irq plotter_status_irq_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sense_i (sense_i),
    .area_i  (area_i),
    .clr15_i (clr15_i),
    .done_i  (done_i),
    .busy_i  (busy_i),
    .irq_o   (irq_o),
    .stat0_o (stat0_o),
    .stat14_o(stat14_o),
    .stat15_o(stat15_o)
);

// File: tb/plotter_status_irq_tb.sv
module plotter_status_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC_STAGES = 2;

    logic clk = 1'b0;
    logic rst_ni, sense_i, area_i, clr15_i, done_i, busy_i, pwr_i;
    logic irq_o, stat0_o, stat14_o, stat15_o;
    int   checks = 0;
    int   errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plotter_status_irq #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .sense_i(sense_i), .area_i(area_i),
        .clr15_i(clr15_i), .done_i(done_i), .busy_i(busy_i), .pwr_i(pwr_i),
        .irq_o(irq_o), .stat0_o(stat0_o), .stat14_o(stat14_o), .stat15_o(stat15_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {irq,b0,b14,b15} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {irq_o, stat0_o, stat14_o, stat15_o};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full eight-step sense; exp_st = {b0,b14,b15}, exp_irq_after = irq once ended
    task automatic sense_cycle(input string req, input logic clr, input logic irq_now,
                               input logic [2:0] exp_st, input logic exp_irq_after);
        sense_i = 1'b1; area_i = 1'b1; clr15_i = clr;
        tick(1);
        check(req, outs(), {irq_now, exp_st});
        tick(7);
        check(req, outs(), {irq_now, exp_st});
        sense_i = 1'b0; area_i = 1'b0; clr15_i = 1'b0;
        tick(1);
        check(req, outs(), {exp_irq_after, 3'b000});
    endtask

    task automatic pulse_done();
        done_i = 1'b1; tick(1); done_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_ni = 1'b0; sense_i = 1'b1; area_i = 1'b1; clr15_i = 1'b0;
        done_i = 1'b1; busy_i = 1'b1; pwr_i = 1'b1;
        tick(3);
        check("R1 reset", outs(), 4'b0000);
        sense_i = 1'b0; area_i = 1'b0; done_i = 1'b0; busy_i = 1'b0; pwr_i = 1'b0;
        tick(1);
        rst_ni = 1'b1;
        tick(SYNC_STAGES + 2);
    endtask

    task automatic t_partial_decode();
        busy_i = 1'b1; pwr_i = 1'b1; tick(SYNC_STAGES + 2);
        sense_i = 1'b1; area_i = 1'b0; tick(3);
        check("R2 strobe only", outs(), 4'b0000);
        sense_i = 1'b0; area_i = 1'b1; tick(3);
        check("R2 area only", outs(), 4'b0000);
        area_i = 1'b0; busy_i = 1'b0; pwr_i = 1'b0; tick(SYNC_STAGES + 2);
    endtask

    task automatic t_power();
        sense_cycle("R3 power off", 1'b0, 1'b0, 3'b000, 1'b0);
        pwr_i = 1'b1; tick(SYNC_STAGES + 1);
        sense_cycle("R3 power on", 1'b0, 1'b0, 3'b001, 1'b0);
    endtask

    task automatic t_busy();
        busy_i = 1'b1; tick(1);
        sense_cycle("R4 busy", 1'b0, 1'b0, 3'b011, 1'b0);
        busy_i = 1'b0; tick(1);
        sense_cycle("R8 release", 1'b0, 1'b0, 3'b001, 1'b0);
    endtask

    task automatic t_complete();
        pulse_done();
        check("R5 set", outs(), 4'b1000);
        tick(20);
        check("R5 sticky", outs(), 4'b1000);
        sense_cycle("R6 pending", 1'b0, 1'b1, 3'b101, 1'b1);
    endtask

    task automatic t_stray_clear();
        clr15_i = 1'b1; tick(3); clr15_i = 1'b0; tick(2);
        check("R10 stray qualifier", outs(), 4'b1000);
        sense_cycle("R10 after stray", 1'b0, 1'b1, 3'b101, 1'b1);
    endtask

    task automatic t_clear();
        sense_cycle("R7 clear sense", 1'b1, 1'b1, 3'b101, 1'b0);
        sense_cycle("R7 later sense", 1'b0, 1'b0, 3'b001, 1'b0);
    endtask

    task automatic t_collide();
        pulse_done();
        sense_i = 1'b1; area_i = 1'b1; clr15_i = 1'b1;
        tick(8);
        check("R9 during", outs(), 4'b1101);
        sense_i = 1'b0; area_i = 1'b0; clr15_i = 1'b0; done_i = 1'b1;
        tick(1);
        done_i = 1'b0;
        check("R9 done wins", outs(), 4'b1000);
        tick(2);
        check("R9 still set", outs(), 4'b1000);
    endtask

    initial begin
        rst_ni = 1'b0; sense_i = 1'b0; area_i = 1'b0; clr15_i = 1'b0;
        done_i = 1'b0; busy_i = 1'b0; pwr_i = 1'b0;
        t_reset();
        t_partial_decode();
        t_power();
        t_busy();
        t_complete();
        t_stray_clear();
        t_clear();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule